// File: doc/BRIEF.md
# Exception Vector and Return-Address Selector

This block sits in the control path of a small real-mode processor core. It looks at each instruction as it completes. The inputs it watches are the divide-fault indication, the trace flag, the opcode and immediate bytes, the ModR/M mode field, the overflow flag, the bounds comparison result, the undefined-opcode flag, the memory-only decode flag and the coprocessor signals. From these it decides whether an exception must be entered.

When an exception is entered, the block issues a one-cycle take pulse. With the pulse it gives the fixed 8-bit vector number and the address the sequencer must push as the return address. Faults on the current instruction return to its first byte, counting prefix bytes, so the instruction runs again. Traps return to the following instruction. Two of the traps are conditional, and each acts as a no-op when its condition is false.

Stack pushes, fetching from the vector table and full instruction decode belong to neighbouring blocks.

Top module: `exc_vector_sel`

## Requirements
- R1: While reset is active, and on the first cycles after it is released, `exc_take` is 0, `exc_vector` is 0 and `exc_ret_addr` is 0.
- R2: All outputs are registered. When `instr_done` is sampled high and at least one exception condition holds, `exc_take` is 1 for exactly the following cycle. In every other case, `exc_take` is 0 in the following cycle.
- R3: `div_err` selects vector 0, and the return address is `start_addr`.
- R4: Opcode 0xCC, or opcode 0xCD with `imm8` = 0x03, selects vector 3 with return address `next_addr`. Opcode 0xCD with any other immediate raises no exception.
- R5: Opcode 0xCE with `ovf_flag`=1 selects vector 4 with return address `next_addr`. With `ovf_flag`=0 it raises no exception.
- R6: Opcode 0x62 with `modrm_mod` not equal to 2'b11 and `bound_oor`=1 selects vector 5 with return address `start_addr`. With `bound_oor`=0 it raises no exception.
- R7: Vector 6 is selected, with return address `start_addr`, when `undef_opcode`=1. It is also selected when `modrm_mod`=2'b11 and either `mem_only_op`=1 or the opcode is 0x62.
- R8: `cop_instr`=1 with `cop_present`=0 selects vector 7 with return address `start_addr`.
- R9: `trace_flag`=1 selects vector 1 with return address `next_addr`, but only when no other condition holds on that instruction.
- R10: When several conditions hold together, the priority is 6, then 7, then 0, then 5, then 3, then 4, then 1.
- R11: In a cycle where `exc_take` is 0, `exc_vector` and `exc_ret_addr` keep the values of the last exception taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_done | input | 1 | An instruction completes this cycle and its conditions are valid |
| start_addr | input | AW | Address of the first byte of the instruction, prefixes included |
| next_addr | input | AW | Address of the following instruction |
| opcode | input | 8 | Primary opcode byte |
| imm8 | input | 8 | First immediate byte |
| modrm_mod | input | 2 | Mode field of the ModR/M byte |
| div_err | input | 1 | Divide by zero or quotient overflow |
| trace_flag | input | 1 | Single-step flag |
| ovf_flag | input | 1 | Arithmetic overflow flag |
| bound_oor | input | 1 | Bounds check found the register out of range |
| undef_opcode | input | 1 | Opcode is not a legal instruction |
| mem_only_op | input | 1 | Instruction requires a memory operand |
| cop_instr | input | 1 | Instruction is a coprocessor instruction |
| cop_present | input | 1 | Coprocessor is installed |
| exc_take | output | 1 | One-cycle exception entry pulse |
| exc_vector | output | 8 | Vector number of the exception taken |
| exc_ret_addr | output | AW | Return address to push |

## Verification
A wrong priority or a bad decode of the opcode and immediate shows up as a wrong vector in the cycle right after the completing instruction. A fault and trap mix-up shows up as the wrong one of the two input addresses on `exc_ret_addr` in that same cycle. A stray load enable shows up one cycle later, when the output values drift on a cycle without a take pulse. The random mix raises several conditions at once, so each link of the priority chain gets stressed.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

  localparam int unsigned VW     = 8;   // vector width
  localparam int unsigned NVEC   = 8;   // vectors handled
  localparam int unsigned NPRIO  = 7;   // populated vectors

  typedef logic [VW-1:0]   vec_t;
  typedef logic [NVEC-1:0] req_t;

  localparam int unsigned VEC_DIV   = 0;
  localparam int unsigned VEC_STEP  = 1;
  localparam int unsigned VEC_BRK   = 3;
  localparam int unsigned VEC_OVF   = 4;
  localparam int unsigned VEC_BOUND = 5;
  localparam int unsigned VEC_ILL   = 6;
  localparam int unsigned VEC_NOCOP = 7;

  // vectors returning to the first byte of the instruction
  localparam req_t FAULT_MASK = req_t'((1 << VEC_DIV) | (1 << VEC_BOUND) |
                                       (1 << VEC_ILL) | (1 << VEC_NOCOP));

  // index 0 is highest priority
  localparam logic [NPRIO-1:0][2:0] PRIO_ORDER =
    {3'(VEC_STEP), 3'(VEC_OVF), 3'(VEC_BRK), 3'(VEC_BOUND),
     3'(VEC_DIV), 3'(VEC_NOCOP), 3'(VEC_ILL)};

endpackage

// File: rtl/exc_rst_sync.sv
`timescale 1ns/1ps
module exc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/exc_decode.sv
`timescale 1ns/1ps
module exc_decode
  import exc_pkg::*;
#(
  parameter logic [7:0] OP_BRK1  = 8'hCC,
  parameter logic [7:0] OP_INTN  = 8'hCD,
  parameter logic [7:0] BRK_IMM  = 8'h03,
  parameter logic [7:0] OP_OVCHK = 8'hCE,
  parameter logic [7:0] OP_BOUND = 8'h62
) (
  input  logic       instr_done,
  input  logic [7:0] opcode,
  input  logic [7:0] imm8,
  input  logic [1:0] modrm_mod,
  input  logic       div_err,
  input  logic       trace_flag,
  input  logic       ovf_flag,
  input  logic       bound_oor,
  input  logic       undef_opcode,
  input  logic       mem_only_op,
  input  logic       cop_instr,
  input  logic       cop_present,
  output req_t       req
);

  logic reg_form;
  logic is_bound;
  logic hit_ill;
  logic hit_bound;
  logic hit_brk;
  logic hit_ovf;
  logic hit_nocop;

  always_comb begin
    reg_form  = (modrm_mod == 2'b11);
    is_bound  = (opcode == OP_BOUND);
    hit_ill   = undef_opcode | ((mem_only_op | is_bound) & reg_form);
    hit_bound = is_bound & ~reg_form & bound_oor;
    hit_brk   = (opcode == OP_BRK1) | ((opcode == OP_INTN) & (imm8 == BRK_IMM));
    hit_ovf   = (opcode == OP_OVCHK) & ovf_flag;
    hit_nocop = cop_instr & ~cop_present;

    req            = '0;
    req[VEC_DIV]   = instr_done & div_err;
    req[VEC_STEP]  = instr_done & trace_flag;
    req[VEC_BRK]   = instr_done & hit_brk;
    req[VEC_OVF]   = instr_done & hit_ovf;
    req[VEC_BOUND] = instr_done & hit_bound;
    req[VEC_ILL]   = instr_done & hit_ill;
    req[VEC_NOCOP] = instr_done & hit_nocop;
  end

endmodule

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
module exc_prio
  import exc_pkg::*;
(
  input  req_t req,
  output logic any,
  output vec_t vec,
  output logic fault
);

  logic [NPRIO:0]   seen;
  logic [NPRIO-1:0] grant;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NPRIO; g++) begin : g_chain
    assign grant[g]  = req[PRIO_ORDER[g]] & ~seen[g];
    assign seen[g+1] = seen[g] | req[PRIO_ORDER[g]];
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NPRIO; i++) begin
      if (grant[i]) vec = vec | vec_t'(PRIO_ORDER[i]);
    end
    any   = seen[NPRIO];
    fault = any & FAULT_MASK[vec[2:0]];
  end

endmodule

// File: rtl/exc_out_reg.sv
`timescale 1ns/1ps
module exc_out_reg
  import exc_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any,
  input  vec_t          vec,
  input  logic          fault,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] next_addr,
  output logic          take_q,
  output vec_t          vec_q,
  output logic [AW-1:0] addr_q
);

  logic          load_en;
  logic          take_d;
  vec_t          vec_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    load_en = any;
    take_d  = any;
    vec_d   = vec;
    addr_d  = fault ? start_addr : next_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      take_q <= take_d;
      if (load_en) begin
        vec_q  <= vec_d;
        addr_q <= addr_d;
      end
    end
  end

endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] next_addr,
  input  logic [7:0]    opcode,
  input  logic [7:0]    imm8,
  input  logic [1:0]    modrm_mod,
  input  logic          div_err,
  input  logic          trace_flag,
  input  logic          ovf_flag,
  input  logic          bound_oor,
  input  logic          undef_opcode,
  input  logic          mem_only_op,
  input  logic          cop_instr,
  input  logic          cop_present,
  output logic          exc_take,
  output logic [7:0]    exc_vector,
  output logic [AW-1:0] exc_ret_addr
);

  logic rst_n_int;
  req_t req;
  logic sel_any;
  vec_t sel_vec;
  logic sel_fault;

  exc_rst_sync #(.STAGES(SYNC_LEN)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  exc_decode i_decode (
    .instr_done   (instr_done),
    .opcode       (opcode),
    .imm8         (imm8),
    .modrm_mod    (modrm_mod),
    .div_err      (div_err),
    .trace_flag   (trace_flag),
    .ovf_flag     (ovf_flag),
    .bound_oor    (bound_oor),
    .undef_opcode (undef_opcode),
    .mem_only_op  (mem_only_op),
    .cop_instr    (cop_instr),
    .cop_present  (cop_present),
    .req          (req)
  );

  exc_prio i_prio (
    .req   (req),
    .any   (sel_any),
    .vec   (sel_vec),
    .fault (sel_fault)
  );

  exc_out_reg #(.AW(AW)) i_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .any        (sel_any),
    .vec        (sel_vec),
    .fault      (sel_fault),
    .start_addr (start_addr),
    .next_addr  (next_addr),
    .take_q     (exc_take),
    .vec_q      (exc_vector),
    .addr_q     (exc_ret_addr)
  );

endmodule

// File: rtl/exc_vector_sel_chk.sv
`timescale 1ns/1ps
module exc_vector_sel_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_done,
  input logic          undef_opcode,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] next_addr,
  input logic          exc_take,
  input logic [7:0]    exc_vector,
  input logic [AW-1:0] exc_ret_addr
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!exc_take && exc_vector == 8'd0 && exc_ret_addr == '0)
        else $error("outputs not cleared in reset");
    end
  end

  assert_take_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    exc_take |-> $past(instr_done));

  assert_legal_vector_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    exc_take |-> (exc_vector inside {8'd0, 8'd1, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7}));

  assert_fault_addr_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (exc_take && (exc_vector inside {8'd0, 8'd5, 8'd6, 8'd7})) |-> exc_ret_addr == $past(start_addr));

  assert_trap_addr_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (exc_take && (exc_vector inside {8'd1, 8'd3, 8'd4})) |-> exc_ret_addr == $past(next_addr));

  assert_undef_wins_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(instr_done && undef_opcode) |-> (exc_take && exc_vector == 8'd6));

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !exc_take |-> ($stable(exc_vector) && $stable(exc_ret_addr)));

endmodule

bind exc_vector_sel exc_vector_sel_chk #(.AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_done   (instr_done),
  .undef_opcode (undef_opcode),
  .start_addr   (start_addr),
  .next_addr    (next_addr),
  .exc_take     (exc_take),
  .exc_vector   (exc_vector),
  .exc_ret_addr (exc_ret_addr)
);

// File: tb/test_exc_vector_sel.sv
`timescale 1ns/1ps
module test_exc_vector_sel;

  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_done;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] next_addr;
  logic [7:0]    opcode;
  logic [7:0]    imm8;
  logic [1:0]    modrm_mod;
  logic          div_err;
  logic          trace_flag;
  logic          ovf_flag;
  logic          bound_oor;
  logic          undef_opcode;
  logic          mem_only_op;
  logic          cop_instr;
  logic          cop_present;
  logic          exc_take;
  logic [7:0]    exc_vector;
  logic [AW-1:0] exc_ret_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]    hold_vec;
  logic [AW-1:0] hold_addr;

  always #2 clk = ~clk;

  exc_vector_sel #(.AW(AW)) i_exc_vector_sel (.*);

  // expected vector from the requirements; -1 means none
  function automatic int ref_vec();
    bit reg_form = (modrm_mod == 2'b11);
    if (!instr_done) return -1;
    if (undef_opcode || ((mem_only_op || opcode == 8'h62) && reg_form)) return 6;
    if (cop_instr && !cop_present) return 7;
    if (div_err) return 0;
    if (opcode == 8'h62 && !reg_form && bound_oor) return 5;
    if (opcode == 8'hCC || (opcode == 8'hCD && imm8 == 8'h03)) return 3;
    if (opcode == 8'hCE && ovf_flag) return 4;
    if (trace_flag) return 1;
    return -1;
  endfunction

  function automatic string tag_of(int v);
    case (v)
      0: return "R3";
      1: return "R9";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    instr_done = 0; opcode = 8'h90; imm8 = 0; modrm_mod = 2'b00;
    div_err = 0; trace_flag = 0; ovf_flag = 0; bound_oor = 0;
    undef_opcode = 0; mem_only_op = 0; cop_instr = 0; cop_present = 1;
  endtask

  // called at negedge with inputs set; checks after next posedge
  task automatic run_cycle(string tag_in);
    int v = ref_vec();
    string tag = (tag_in == "") ? tag_of(v) : tag_in;
    logic [AW-1:0] ea;
    if (v >= 0) begin
      ea = (v == 0 || v == 5 || v == 6 || v == 7) ? start_addr : next_addr;
      hold_vec = 8'(v);
      hold_addr = ea;
    end
    @(posedge clk); #1;
    chk((v >= 0) ? tag : "R2", "take", exc_take, (v >= 0));
    chk(tag, "vector", exc_vector, hold_vec);
    chk(tag, "ret_addr", exc_ret_addr, hold_addr);
    @(negedge clk);
    clear_in();
    start_addr = AW'($urandom);
    next_addr = AW'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in();
    start_addr = 20'h01000; next_addr = 20'h01003;
    rst_n = 0;
    hold_vec = 0; hold_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "take in reset", exc_take, 0);
    chk("R1", "vector in reset", exc_vector, 0);
    chk("R1", "addr in reset", exc_ret_addr, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "take after reset", exc_take, 0);
    chk("R1", "addr after reset", exc_ret_addr, 0);

    // directed cases
    instr_done = 1; div_err = 1; run_cycle("R3");
    instr_done = 1; opcode = 8'hCC; run_cycle("R4");
    instr_done = 1; opcode = 8'hCD; imm8 = 8'h03; run_cycle("R4");
    instr_done = 1; opcode = 8'hCD; imm8 = 8'h21; run_cycle("R4");
    instr_done = 1; opcode = 8'hCE; ovf_flag = 1; run_cycle("R5");
    instr_done = 1; opcode = 8'hCE; ovf_flag = 0; run_cycle("R5");
    instr_done = 1; opcode = 8'h62; modrm_mod = 2'b10; bound_oor = 1; run_cycle("R6");
    instr_done = 1; opcode = 8'h62; modrm_mod = 2'b01; bound_oor = 0; run_cycle("R6");
    instr_done = 1; opcode = 8'h62; modrm_mod = 2'b11; bound_oor = 1; run_cycle("R7");
    instr_done = 1; mem_only_op = 1; modrm_mod = 2'b11; run_cycle("R7");
    instr_done = 1; mem_only_op = 1; modrm_mod = 2'b00; run_cycle("R7");
    instr_done = 1; undef_opcode = 1; run_cycle("R7");
    instr_done = 1; cop_instr = 1; cop_present = 0; run_cycle("R8");
    instr_done = 1; cop_instr = 1; cop_present = 1; run_cycle("R8");
    instr_done = 1; trace_flag = 1; run_cycle("R9");
    instr_done = 1; trace_flag = 1; opcode = 8'hCC; run_cycle("R9");
    instr_done = 0; div_err = 1; trace_flag = 1; run_cycle("R2");
    instr_done = 1; undef_opcode = 1; cop_instr = 1; cop_present = 0; div_err = 1; run_cycle("R10");
    instr_done = 1; cop_instr = 1; cop_present = 0; div_err = 1; run_cycle("R10");
    instr_done = 1; div_err = 1; opcode = 8'h62; bound_oor = 1; run_cycle("R10");
    instr_done = 1; opcode = 8'h62; bound_oor = 1; trace_flag = 1; run_cycle("R10");
    instr_done = 1; div_err = 1; opcode = 8'hCC; trace_flag = 1; run_cycle("R10");
    instr_done = 1; opcode = 8'hCE; ovf_flag = 1; trace_flag = 1; run_cycle("R10");
    instr_done = 0; run_cycle("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 4);
      instr_done   = ($urandom_range(0, 9) < 8);
      case (sel)
        0: opcode = 8'hCC;
        1: opcode = 8'hCD;
        2: opcode = 8'hCE;
        3: opcode = 8'h62;
        default: opcode = 8'($urandom);
      endcase
      imm8         = ($urandom_range(0, 1) == 0) ? 8'h03 : 8'($urandom);
      modrm_mod    = 2'($urandom);
      div_err      = ($urandom_range(0, 7) == 0);
      trace_flag   = ($urandom_range(0, 3) == 0);
      ovf_flag     = 1'($urandom);
      bound_oor    = 1'($urandom);
      undef_opcode = ($urandom_range(0, 9) == 0);
      mem_only_op  = ($urandom_range(0, 5) == 0);
      cop_instr    = ($urandom_range(0, 5) == 0);
      cop_present  = 1'($urandom);
      run_cycle("");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule